// File: doc/BRIEF.md
# Codec Link Global Control

This block holds the 32-bit global control word of a serial codec link and runs the logic behind it. A host reaches it through a simple synchronous bus. The control word carries five things: an active-low cold reset for the link and codec, a warm-reset request, a link shut-off, a general-purpose-input interrupt enable, and three resume interrupt enables, one per serial data input. A companion status word latches general-purpose-input changes and resume events, and software clears those latches by writing ones.

The warm-reset request is handled by a three-state sequencer with the states IDLE, PULSE and WAIT. IDLE→PULSE is taken when software writes a 1 to the warm bit while the bit clock is stopped. PULSE→WAIT is taken after the sync line has been held high for `SYNC_CYCLES` system cycles. WAIT→IDLE is taken on the first rising bit-clock edge seen after that. The warm bit reads as 1 in PULSE and in WAIT.

Bit-clock activity is tracked by synchronising the bit clock into the system clock and counting the system cycles since its last rising edge. The clock counts as stopped once `BCLK_TIMEOUT` cycles pass without an edge. A separate power-state wake reset clears only the general-purpose-input interrupt enable.

Top module: `cdl_glob_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000 and the status word reads 0. Bits 31:7 of the control word always read 0, and writes to them have no effect.
- R2: Any change on `gpi_i` sets status bit 0 whether or not control bit 0 (interrupt enable) is set. This status bit contributes to `irq_o` only while control bit 0 is 1, and writing 1 to status bit 0 clears it.
- R3: Control bit 1 is an active-low cold reset. While link shut-off is 0, `link_rst_n_o` equals control bit 1.
- R4: Writing 1 to control bit 2 (warm reset) while the bit clock is active has no effect, and bit 2 keeps reading 0.
- R5: An accepted warm reset drives `link_sync_o` high for exactly `SYNC_CYCLES` cycles. Control bit 2 then keeps reading 1 until a rising bit-clock edge is detected, and afterwards reads 0.
- R6: While control bit 3 (link shut-off) is 1, `link_rst_n_o`, `link_sync_o` and `link_oe_o` are all 0.
- R7: A high level on `resume_i[k]` sets status bit k+1. That bit stays set until software writes 1 to it. It raises `irq_o` only while control bit 4+k is 1.
- R8: A pulse on `pm_wake_rst` clears control bit 0 and leaves every other control bit unchanged.
- R9: The control word sits at byte offset 0x3C and the status word at 0x40. Only accesses with `bus_be` = 4'hF at exactly those offsets respond. Any other write is ignored, and any other read returns 0.
- R10: The bit clock counts as stopped only after `BCLK_TIMEOUT` system cycles pass with no rising edge. Until then, a warm-reset request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low main reset |
| pm_wake_rst | input | 1 | Power-state wake reset pulse, clears the GPI interrupt enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bit_clk | input | 1 | Link bit clock, asynchronous |
| gpi_i | input | GPI_W | General-purpose inputs, asynchronous |
| resume_i | input | 3 | Resume event per serial data input, synchronous |
| link_rst_n_o | output | 1 | Link reset, active low |
| link_sync_o | output | 1 | Link sync line (warm-reset wake pulse) |
| link_oe_o | output | 1 | Link output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is the warm-reset path. It needs the bit clock stopped long enough to pass the activity timeout, then a request, the full sync pulse, a long WAIT with the clock still stopped, and finally a restarted clock. The bench controls a free-running bit-clock generator, which lets it stop the generator and probe a request inside the timeout window (refused). It then probes again after the window (accepted), measures the sync width at falling edges, and only then restarts the clock. Random control writes made while the clock runs test the refusal of the warm bit many times over.

// File: rtl/cdl_glob_pkg.sv
package cdl_glob_pkg;

    localparam int N_SDIN      = 3;
    localparam int CTRL_USED_W = 7;

    localparam int CB_GIE    = 0;
    localparam int CB_COLD_N = 1;
    localparam int CB_WARM   = 2;
    localparam int CB_LSO    = 3;
    localparam int CB_RES0   = 4;

    localparam logic [7:0] REG_OFS_CTRL = 8'h3C;
    localparam logic [7:0] REG_OFS_STAT = 8'h40;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_PULSE = 2'd1,
        WS_WAIT  = 2'd2
    } warm_state_e;

endpackage

// File: rtl/cdl_bclk_mon.sv
module cdl_bclk_mon #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    output logic rise_o,
    output logic active_o
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [CW-1:0] idle_q;

    assign rise_o   = sync_q[1] & ~prev_q;
    assign active_o = idle_q < CW'(TIMEOUT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            idle_q <= CW'(TIMEOUT);
        end else begin
            sync_q <= {sync_q[0], bit_clk};
            prev_q <= sync_q[1];
            if (rise_o)
                idle_q <= '0;
            else if (idle_q != CW'(TIMEOUT))
                idle_q <= idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/cdl_warm_fsm.sv
module cdl_warm_fsm
    import cdl_glob_pkg::*;
#(
    parameter int SYNC_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bclk_rise_i,
    output logic busy_o,
    output logic sync_o
);
    localparam int CW = $clog2(SYNC_CYCLES + 1);

    warm_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          pulse_done;

    assign pulse_done = (cnt_q == CW'(SYNC_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (st_q == WS_PULSE) cnt_q <= cnt_q + 1'b1;
        else                      cnt_q <= '0;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_IDLE:  if (start_i)     st_d = WS_PULSE;
            WS_PULSE: if (pulse_done)  st_d = WS_WAIT;
            WS_WAIT:  if (bclk_rise_i) st_d = WS_IDLE;
            default:                   st_d = WS_IDLE;
        endcase
    end

    always_comb begin
        busy_o = 1'b0;
        sync_o = 1'b0;
        unique case (st_q)
            WS_IDLE:  ;
            WS_PULSE: begin busy_o = 1'b1; sync_o = 1'b1; end
            WS_WAIT:  busy_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/cdl_irq_unit.sv
module cdl_irq_unit
    import cdl_glob_pkg::*;
#(
    parameter int GPI_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPI_W-1:0]  gpi_i,
    input  logic [N_SDIN-1:0] resume_i,
    input  logic              gie_i,
    input  logic [N_SDIN-1:0] res_en_i,
    input  logic [N_SDIN:0]   clr_i,
    output logic [N_SDIN:0]   stat_o,
    output logic              irq_o
);
    logic [GPI_W-1:0] gpi_s1_q, gpi_s2_q, gpi_prev_q;
    logic             gpi_chg;
    logic [N_SDIN:0]  stat_q;

    assign gpi_chg = |(gpi_s2_q ^ gpi_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpi_s1_q   <= '0;
            gpi_s2_q   <= '0;
            gpi_prev_q <= '0;
        end else begin
            gpi_s1_q   <= gpi_i;
            gpi_s2_q   <= gpi_s1_q;
            gpi_prev_q <= gpi_s2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[0] <= 1'b0;
        else        stat_q[0] <= gpi_chg | (stat_q[0] & ~clr_i[0]);
    end

    for (genvar k = 0; k < N_SDIN; k++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[k+1] <= 1'b0;
            else        stat_q[k+1] <= resume_i[k] | (stat_q[k+1] & ~clr_i[k+1]);
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = (stat_q[0] & gie_i) | (|(stat_q[N_SDIN:1] & res_en_i));
endmodule

// File: rtl/cdl_glob_ctrl.sv
module cdl_glob_ctrl
    import cdl_glob_pkg::*;
#(
    parameter int GPI_W        = 4,
    parameter int BCLK_TIMEOUT = 64,
    parameter int SYNC_CYCLES  = 128,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm_wake_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              bit_clk,
    input  logic [GPI_W-1:0]  gpi_i,
    input  logic [N_SDIN-1:0] resume_i,
    output logic              link_rst_n_o,
    output logic              link_sync_o,
    output logic              link_oe_o,
    output logic              irq_o
);
    logic              full_word, hit_ctrl, hit_stat;
    logic              wr_ctrl, wr_stat, rd_ctrl, rd_stat;
    logic              gie_q, cold_n_q, lso_q;
    logic [N_SDIN-1:0] res_en_q;
    logic              bclk_rise, bclk_active;
    logic              warm_start, warm_busy, warm_sync;
    logic [N_SDIN:0]   clr_mask, stat_q;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CTRL_USED_W];

    assign full_word = bus_sel & (bus_be == 4'hF);
    assign hit_ctrl  = full_word & (bus_addr == ADDR_W'(REG_OFS_CTRL));
    assign hit_stat  = full_word & (bus_addr == ADDR_W'(REG_OFS_STAT));
    assign wr_ctrl   = hit_ctrl & bus_wr;
    assign wr_stat   = hit_stat & bus_wr;
    assign rd_ctrl   = hit_ctrl & ~bus_wr;
    assign rd_stat   = hit_stat & ~bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q    <= 1'b0;
            cold_n_q <= 1'b0;
            lso_q    <= 1'b0;
            res_en_q <= '0;
        end else begin
            if (wr_ctrl) begin
                gie_q    <= bus_wdata[CB_GIE];
                cold_n_q <= bus_wdata[CB_COLD_N];
                lso_q    <= bus_wdata[CB_LSO];
                res_en_q <= bus_wdata[CB_RES0 +: N_SDIN];
            end
            if (pm_wake_rst)
                gie_q <= 1'b0;
        end
    end

    cdl_bclk_mon #(
        .TIMEOUT (BCLK_TIMEOUT)
    ) u_bclk_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_clk  (bit_clk),
        .rise_o   (bclk_rise),
        .active_o (bclk_active)
    );

    assign warm_start = wr_ctrl & bus_wdata[CB_WARM] & ~bclk_active & ~warm_busy;

    cdl_warm_fsm #(
        .SYNC_CYCLES (SYNC_CYCLES)
    ) u_warm_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (warm_start),
        .bclk_rise_i (bclk_rise),
        .busy_o      (warm_busy),
        .sync_o      (warm_sync)
    );

    assign clr_mask = wr_stat ? bus_wdata[N_SDIN:0] : '0;

    cdl_irq_unit #(
        .GPI_W (GPI_W)
    ) u_irq_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpi_i    (gpi_i),
        .resume_i (resume_i),
        .gie_i    (gie_q),
        .res_en_i (res_en_q),
        .clr_i    (clr_mask),
        .stat_o   (stat_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ctrl) begin
            bus_rdata[CB_GIE]               = gie_q;
            bus_rdata[CB_COLD_N]            = cold_n_q;
            bus_rdata[CB_WARM]              = warm_busy;
            bus_rdata[CB_LSO]               = lso_q;
            bus_rdata[CB_RES0 +: N_SDIN]    = res_en_q;
        end else if (rd_stat) begin
            bus_rdata[N_SDIN:0]             = stat_q;
        end
    end

    assign link_oe_o    = ~lso_q;
    assign link_rst_n_o = cold_n_q & ~lso_q;
    assign link_sync_o  = warm_sync & ~lso_q;
endmodule

// File: rtl/cdl_glob_ctrl_chk.sv
module cdl_glob_ctrl_chk #(
    parameter int N_RES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pm_wake_rst,
    input logic [31:0]      bus_rdata,
    input logic             link_rst_n_o,
    input logic             link_sync_o,
    input logic             link_oe_o,
    input logic [N_RES-1:0] resume_i,
    input logic             gie_q,
    input logic             cold_n_q,
    input logic             lso_q,
    input logic [N_RES:0]   stat_q,
    input logic             wr_ctrl,
    input logic             warm_data,
    input logic             bclk_rise,
    input logic             bclk_active,
    input logic             warm_busy
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:7] == 25'd0);

    // R3
    cold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cold_n_q |-> !link_rst_n_o);

    // R4
    warm_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && warm_data && bclk_active && !warm_busy) |=> !warm_busy);

    // R5
    warm_done_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_busy) |-> $past(bclk_rise));

    // R5
    sync_inside_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_sync_o |-> warm_busy);

    // R6
    shutoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lso_q |-> (!link_rst_n_o && !link_sync_o && !link_oe_o));

    // R7
    resume_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i != '0) |=> ((stat_q[N_RES:1] & $past(resume_i)) == $past(resume_i)));

    // R8
    wake_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wake_rst |=> !gie_q);

    // R10
    edge_means_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |=> bclk_active);
endmodule

bind cdl_glob_ctrl cdl_glob_ctrl_chk #(
    .N_RES (cdl_glob_pkg::N_SDIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pm_wake_rst  (pm_wake_rst),
    .bus_rdata    (bus_rdata),
    .link_rst_n_o (link_rst_n_o),
    .link_sync_o  (link_sync_o),
    .link_oe_o    (link_oe_o),
    .resume_i     (resume_i),
    .gie_q        (gie_q),
    .cold_n_q     (cold_n_q),
    .lso_q        (lso_q),
    .stat_q       (stat_q),
    .wr_ctrl      (wr_ctrl),
    .warm_data    (bus_wdata[2]),
    .bclk_rise    (bclk_rise),
    .bclk_active  (bclk_active),
    .warm_busy    (warm_busy)
);

// File: tb/cdl_glob_ctrl_bench.sv
module cdl_glob_ctrl_bench;
    localparam int GPI_W    = 4;
    localparam int TIMEOUT  = 64;
    localparam int SYNC_CYC = 128;
    localparam logic [7:0] A_CTRL = 8'h3C;
    localparam logic [7:0] A_STAT = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm_wake_rst = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bit_clk = 1'b0;
    logic        bclk_run = 1'b1;
    logic [GPI_W-1:0] gpi = '0;
    logic [2:0]  resume = '0;
    logic        link_rst_n_o, link_sync_o, link_oe_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [6:0] exp_ctrl;
    logic [3:0] exp_stat;

    always #4 clk = ~clk;
    always begin
        #16;
        if (bclk_run) bit_clk = ~bit_clk;
    end

    cdl_glob_ctrl #(
        .GPI_W        (GPI_W),
        .BCLK_TIMEOUT (TIMEOUT),
        .SYNC_CYCLES  (SYNC_CYC),
        .ADDR_W       (8)
    ) u_cdl_glob_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pm_wake_rst  (pm_wake_rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bit_clk      (bit_clk),
        .gpi_i        (gpi),
        .resume_i     (resume),
        .link_rst_n_o (link_rst_n_o),
        .link_sync_o  (link_sync_o),
        .link_oe_o    (link_oe_o),
        .irq_o        (irq_o)
    );

    function automatic logic model_irq(input logic [6:0] c, input logic [3:0] s);
        return (s[0] & c[0]) | (|(s[3:1] & c[6:4]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int          cnt;
        void'($urandom(32'd5151));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        bus_read(A_CTRL, 4'hF, rd); check("R1 ctrl reset", rd, 32'h0);
        bus_read(A_STAT, 4'hF, rd); check("R1 stat reset", rd, 32'h0);
        check("R3 rst_n at reset", {31'd0, link_rst_n_o}, 32'd0);
        check("R6 oe at reset", {31'd0, link_oe_o}, 32'd1);
        check("R1 irq at reset", {31'd0, irq_o}, 32'd0);

        // R1 R4 all-ones write while bit clock runs
        wait_cyc(20);
        bus_write(A_CTRL, 4'hF, 32'hFFFF_FFFF);
        bus_read(A_CTRL, 4'hF, rd); check("R1 R4 all ones", rd, 32'h0000_007B);
        // R6 shut-off
        check("R6 rst_n low", {31'd0, link_rst_n_o}, 32'd0);
        check("R6 oe low", {31'd0, link_oe_o}, 32'd0);

        // R3 cold reset release
        bus_write(A_CTRL, 4'hF, 32'h0000_0002);
        check("R3 rst_n released", {31'd0, link_rst_n_o}, 32'd1);
        check("R6 oe restored", {31'd0, link_oe_o}, 32'd1);
        bus_write(A_CTRL, 4'hF, 32'h0000_0000);
        check("R3 rst_n asserted", {31'd0, link_rst_n_o}, 32'd0);
        bus_write(A_CTRL, 4'hF, 32'h0000_0002);

        // R10 request inside the timeout window is refused
        bclk_run = 1'b0;
        wait_cyc(20);
        bus_write(A_CTRL, 4'hF, 32'h0000_0006);
        bus_read(A_CTRL, 4'hF, rd); check("R10 early warm refused", rd, 32'h2);

        // R5 accepted warm reset
        wait_cyc(TIMEOUT + 20);
        bus_write(A_CTRL, 4'hF, 32'h0000_0006);
        cnt = 0;
        while (link_sync_o && cnt < 4 * SYNC_CYC) begin
            cnt++;
            @(negedge clk);
        end
        check("R5 sync width", cnt, SYNC_CYC);
        wait_cyc(50);
        bus_read(A_CTRL, 4'hF, rd); check("R5 warm held while stopped", rd, 32'h6);
        check("R5 sync low in wait", {31'd0, link_sync_o}, 32'd0);
        bclk_run = 1'b1;
        wait_cyc(20);
        bus_read(A_CTRL, 4'hF, rd); check("R5 warm self-cleared", rd, 32'h2);

        // R2 GPI change with interrupt disabled
        gpi = 4'h1;
        wait_cyc(6);
        bus_read(A_STAT, 4'hF, rd); check("R2 status set while disabled", rd, 32'h1);
        check("R2 no irq while disabled", {31'd0, irq_o}, 32'd0);
        bus_write(A_CTRL, 4'hF, 32'h0000_0003);
        check("R2 irq when enabled", {31'd0, irq_o}, 32'd1);
        bus_write(A_STAT, 4'hF, 32'h0000_0001);
        check("R2 irq cleared", {31'd0, irq_o}, 32'd0);

        // R8 wake reset clears only bit 0
        bus_write(A_CTRL, 4'hF, 32'h0000_0073);
        @(negedge clk); pm_wake_rst = 1'b1;
        @(negedge clk); pm_wake_rst = 1'b0;
        bus_read(A_CTRL, 4'hF, rd); check("R8 wake clears gie", rd, 32'h72);

        // R9 misaligned / partial accesses
        bus_write(A_CTRL + 8'd1, 4'hF, 32'h0000_000B);
        bus_write(A_CTRL, 4'h7, 32'h0000_000B);
        bus_write(A_CTRL, 4'h1, 32'h0000_000B);
        bus_read(A_CTRL, 4'hF, rd); check("R9 stray writes ignored", rd, 32'h72);
        bus_read(A_CTRL + 8'd1, 4'hF, rd); check("R9 offset read zero", rd, 32'h0);
        bus_read(A_CTRL, 4'h3, rd); check("R9 partial read zero", rd, 32'h0);

        // R7 directed: event with enable off then on
        bus_write(A_CTRL, 4'hF, 32'h0000_0002);
        @(negedge clk); resume = 3'b010;
        @(negedge clk); resume = 3'b000;
        wait_cyc(2);
        check("R7 no irq when disabled", {31'd0, irq_o}, 32'd0);
        bus_read(A_STAT, 4'hF, rd); check("R7 latched", rd, 32'h4);
        bus_write(A_CTRL, 4'hF, 32'h0000_0022);
        check("R7 irq when enabled", {31'd0, irq_o}, 32'd1);
        bus_write(A_STAT, 4'hF, 32'h0000_0004);
        check("R7 cleared", {31'd0, irq_o}, 32'd0);

        // randomized: R1 R4 R2 R7
        exp_ctrl = 7'h22;
        exp_stat = 4'h0;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] wd;
            logic [2:0]  rm;
            logic [3:0]  cm;
            wd = $urandom;
            bus_write(A_CTRL, 4'hF, wd);
            exp_ctrl = wd[6:0] & 7'h7B;
            bus_read(A_CTRL, 4'hF, rd); check("R1 R4 random ctrl", rd, {25'd0, exp_ctrl});
            if ($urandom_range(0, 1) == 1) begin
                gpi = gpi ^ (4'h1 << $urandom_range(0, GPI_W - 1));
                wait_cyc(6);
                exp_stat[0] = 1'b1;
            end
            rm = 3'($urandom);
            @(negedge clk); resume = rm;
            @(negedge clk); resume = 3'b000;
            exp_stat[3:1] = exp_stat[3:1] | rm;
            wait_cyc(1);
            bus_read(A_STAT, 4'hF, rd); check("R2 R7 random stat", rd, {28'd0, exp_stat});
            check("R2 R7 random irq", {31'd0, irq_o}, {31'd0, model_irq(exp_ctrl, exp_stat)});
            cm = 4'($urandom);
            bus_write(A_STAT, 4'hF, {28'd0, cm});
            exp_stat = exp_stat & ~cm;
            check("R2 R7 irq after clear", {31'd0, irq_o}, {31'd0, model_irq(exp_ctrl, exp_stat)});
        end

        finish_run();
    end
endmodule